// File: doc/BRIEF.md
# Debug Bus Access Comparator Unit

This block observes a CPU bus and reports when an access meets the conditions held in three independent debug comparators, called A, B and C. Each comparator holds an address and raises its own flag when an access starts at exactly that address. An access to a neighbouring word that only overlaps the address does not count. A comparator can also require a particular access direction.

Comparator A can also test the data bus. A per-bit mask is formed from a high-byte mask and a low-byte mask, and the test can be inverted so that A fires when the data differs from the stored value. Comparator B can also require a particular access size. Comparator C checks the address and the direction only.

The register values for the comparators arrive as plain inputs. A bus access is marked by a one-cycle strobe. The flags are registered and stay high for one clock for each access that qualifies.

Top module: `dbg_cmp_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `match` is 3'b000 until a qualifying access has been sampled.
- R2: A comparator whose `cmpEn` bit is 0 never asserts its `match` bit, whatever the bus carries.
- R3: An address hit needs `busAddr` to equal the comparator address exactly. A word access at address n-1 gives no match for a comparator set to n.
- R4: Comparators A and C ignore the access size. With `busWord` at 1 (word) or 0 (byte), an access to their address matches.
- R5: On comparator B, when `sizeEnB` is 0 both sizes match. When `sizeEnB` is 1, only an access whose `busWord` equals `sizeWordB` matches (1 = word, 0 = byte).
- R6: Comparator A also requires `(busData ^ cmpDataA) & {maskHiA, maskLoA}` to be zero. A mask bit of 1 compares that bit and a mask bit of 0 ignores it. Bits [15:8] of `busData` carry the byte at the lower address, so a byte access is compared by setting the high byte and using `maskLoA` = 0x00.
- R7: When `notEqA` is 1, the data condition of comparator A is inverted. A then matches only when the masked data differs from the stored value.
- R8: When `cmpDirEn[i]` is 1, comparator i matches only if `busWrite` equals `cmpDirWr[i]` (1 = write). When `cmpDirEn[i]` is 0, reads and writes both qualify.
- R9: The flags are sampled on the rising edge where `busValid` is 1 and appear on the next cycle. After a rising edge with `busValid` at 0, `match` is 0.
- R10: `match[0]`, `match[1]` and `match[2]` report comparators A, B and C in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | One-cycle strobe that marks a bus access |
| busAddr | input | 16 | Start address of the access |
| busData | input | 16 | Data of the access; the byte at the lower address is in [15:8] |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWord | input | 1 | 1 = word access, 0 = byte access |
| cmpEn | input | 3 | Enable for comparators C, B, A (bits 2..0) |
| cmpDirEn | input | 3 | Direction check enable for each comparator |
| cmpDirWr | input | 3 | Required direction for each comparator |
| cmpAddrA | input | 16 | Address of comparator A |
| cmpAddrB | input | 16 | Address of comparator B |
| cmpAddrC | input | 16 | Address of comparator C |
| cmpDataA | input | 16 | Data value of comparator A |
| maskHiA | input | 8 | Mask for data bits [15:8] |
| maskLoA | input | 8 | Mask for data bits [7:0] |
| notEqA | input | 1 | Inverts the data test of comparator A |
| sizeEnB | input | 1 | Enables the size check on comparator B |
| sizeWordB | input | 1 | Required size for comparator B (1 = word) |
| match | output | 3 | Registered match flags |

## Verification
The hardest case to reach from the ports is an access that is close to a match but must still fail. Examples are a word access at n-1 that covers address n, a word access that comparator B must reject when it is set for bytes, and a data value that differs only in a masked-in bit. The stimulus reaches each of these by holding the comparator registers fixed and changing a single bus field between two accesses. Each such pair gives a hit followed by a miss, and each access is followed by an idle cycle so that a flag left high for two cycles is also detected.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int NUM_CMP = 3;
  localparam int CMP_A = 0;
  localparam int CMP_B = 1;
  localparam int CMP_C = 2;

  // Control-to-datapath strobes
  typedef struct packed {
    logic               sample;  // a bus access is present this cycle
    logic [NUM_CMP-1:0] armed;   // comparator enabled and qualified
  } cmpStrobe_t;
endpackage

// File: rtl/dbg_cmp_ctrl.sv
module dbg_cmp_ctrl
  import dbg_cmp_pkg::*;
(
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               busWord,
  input  logic [NUM_CMP-1:0] cmpEn,
  input  logic [NUM_CMP-1:0] cmpDirEn,
  input  logic [NUM_CMP-1:0] cmpDirWr,
  input  logic               sizeEnB,
  input  logic               sizeWordB,
  output cmpStrobe_t         strobe
);
  logic [NUM_CMP-1:0] dirOk;
  logic [NUM_CMP-1:0] sizeOk;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_qual
    assign dirOk[i] = !cmpDirEn[i] || (busWrite == cmpDirWr[i]);
    if (i == CMP_B) begin : g_size
      assign sizeOk[i] = !sizeEnB || (busWord == sizeWordB);
    end else begin : g_nosize
      assign sizeOk[i] = 1'b1;
    end
  end

  always_comb begin
    strobe.sample = busValid;
    strobe.armed  = cmpEn & dirOk & sizeOk & {NUM_CMP{busValid}};
  end
endmodule

// File: rtl/dbg_cmp_dp.sv
module dbg_cmp_dp
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cmpStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [DATA_W-1:0]              busData,
  input  logic [NUM_CMP-1:0][ADDR_W-1:0] cmpAddr,
  input  logic [DATA_W-1:0]              cmpDataA,
  input  logic [DATA_W-1:0]              dataMaskA,
  input  logic                           notEqA,
  output logic [NUM_CMP-1:0]             match
);
  logic [NUM_CMP-1:0] addrHit;
  logic [NUM_CMP-1:0] dataOk;
  logic               dataDiff;

  assign dataDiff = |((busData ^ cmpDataA) & dataMaskA);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign addrHit[i] = (busAddr == cmpAddr[i]);
    if (i == CMP_A) begin : g_data
      assign dataOk[i] = notEqA ? dataDiff : !dataDiff;
    end else begin : g_nodata
      assign dataOk[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              match <= '0;
    else if (strobe.sample) match <= strobe.armed & addrHit & dataOk;
    else                    match <= '0;
  end
endmodule

// File: rtl/dbg_cmp_unit.sv
module dbg_cmp_unit
  import dbg_cmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWrite,
  input  logic              busWord,
  input  logic [2:0]        cmpEn,
  input  logic [2:0]        cmpDirEn,
  input  logic [2:0]        cmpDirWr,
  input  logic [ADDR_W-1:0] cmpAddrA,
  input  logic [ADDR_W-1:0] cmpAddrB,
  input  logic [ADDR_W-1:0] cmpAddrC,
  input  logic [DATA_W-1:0] cmpDataA,
  input  logic [HALF_W-1:0] maskHiA,
  input  logic [HALF_W-1:0] maskLoA,
  input  logic              notEqA,
  input  logic              sizeEnB,
  input  logic              sizeWordB,
  output logic [2:0]        match
);
  cmpStrobe_t strobe;
  logic [NUM_CMP-1:0][ADDR_W-1:0] cmpAddr;

  assign cmpAddr[CMP_A] = cmpAddrA;
  assign cmpAddr[CMP_B] = cmpAddrB;
  assign cmpAddr[CMP_C] = cmpAddrC;

  dbg_cmp_ctrl ctrl_i (
    .busValid (busValid),
    .busWrite (busWrite),
    .busWord  (busWord),
    .cmpEn    (cmpEn),
    .cmpDirEn (cmpDirEn),
    .cmpDirWr (cmpDirWr),
    .sizeEnB  (sizeEnB),
    .sizeWordB(sizeWordB),
    .strobe   (strobe)
  );

  dbg_cmp_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busData  (busData),
    .cmpAddr  (cmpAddr),
    .cmpDataA (cmpDataA),
    .dataMaskA({maskHiA, maskLoA}),
    .notEqA   (notEqA),
    .match    (match)
  );
endmodule

// File: rtl/dbg_cmp_chk.sv
module dbg_cmp_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              busWord,
  input logic [2:0]        cmpEn,
  input logic [2:0]        cmpDirEn,
  input logic [2:0]        cmpDirWr,
  input logic [ADDR_W-1:0] cmpAddrA,
  input logic [ADDR_W-1:0] cmpAddrB,
  input logic [ADDR_W-1:0] cmpAddrC,
  input logic              sizeEnB,
  input logic              sizeWordB,
  input logic [2:0]        match
);
  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> (match == 3'b000));
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpEn == 3'b000) |=> (match == 3'b000));
  // R3
  addr_miss_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != cmpAddrA) |=> !match[0]);
  // R3
  addr_miss_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != cmpAddrB) |=> !match[1]);
  // R3
  addr_miss_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != cmpAddrC) |=> !match[2]);
  // R5
  size_reject_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && sizeEnB && busWord != sizeWordB) |=> !match[1]);
  // R8
  dir_reject_c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && cmpDirEn[2] && busWrite != cmpDirWr[2]) |=> !match[2]);
  // R4
  c_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && cmpEn[2] && busAddr == cmpAddrC &&
     (!cmpDirEn[2] || busWrite == cmpDirWr[2])) |=> match[2]);
endmodule

bind dbg_cmp_unit dbg_cmp_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
  .busWrite(busWrite), .busWord(busWord), .cmpEn(cmpEn),
  .cmpDirEn(cmpDirEn), .cmpDirWr(cmpDirWr), .cmpAddrA(cmpAddrA),
  .cmpAddrB(cmpAddrB), .cmpAddrC(cmpAddrC), .sizeEnB(sizeEnB),
  .sizeWordB(sizeWordB), .match(match)
);

// File: tb/dbg_cmp_unit_tb_top.sv
module dbg_cmp_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0;
  logic [15:0] busAddr = '0, busData = '0;
  logic busWrite = 1'b0, busWord = 1'b0;
  logic [2:0] cmpEn = '0, cmpDirEn = '0, cmpDirWr = '0;
  logic [15:0] cmpAddrA = '0, cmpAddrB = '0, cmpAddrC = '0, cmpDataA = '0;
  logic [7:0] maskHiA = '0, maskLoA = '0;
  logic notEqA = 1'b0, sizeEnB = 1'b0, sizeWordB = 1'b0;
  logic [2:0] match;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_cmp_unit dut_i (.*);

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (match !== exp) begin
      errors++;
      $display("FAIL %s match=%b expected=%b", req, match, exp);
    end
  endtask

  // One access, then check the flag in the next cycle and idle after it
  task automatic access(input string req, input logic [15:0] a, input logic [15:0] d,
                        input logic wr, input logic wd, input logic [2:0] exp);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busData = d; busWrite = wr; busWord = wd;
    @(negedge clk);
    busValid = 1'b0;
    check(req, exp);
    @(negedge clk);
    check("R9", 3'b000);
  endtask

  task automatic base_cfg();
    cmpEn = 3'b111; cmpDirEn = '0; cmpDirWr = '0;
    cmpAddrA = 16'h1000; cmpAddrB = 16'h2000; cmpAddrC = 16'h1000;
    cmpDataA = '0; maskHiA = '0; maskLoA = '0; notEqA = 1'b0;
    sizeEnB = 1'b0; sizeWordB = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); check("R1", 3'b000);
    rstN = 1'b1;
    @(negedge clk); check("R1", 3'b000);
  endtask

  task automatic t_disabled();
    base_cfg(); cmpEn = 3'b000;
    access("R2", 16'h1000, 16'h0, 1'b1, 1'b1, 3'b000);
    access("R2", 16'h2000, 16'h0, 1'b0, 1'b0, 3'b000);
    cmpEn = 3'b010;
    access("R2", 16'h1000, 16'h0, 1'b1, 1'b1, 3'b000);
  endtask

  task automatic t_exact();
    base_cfg();
    access("R4 R10", 16'h1000, 16'h0, 1'b0, 1'b1, 3'b101);
    access("R4", 16'h1000, 16'h0, 1'b1, 1'b0, 3'b101);
    access("R3", 16'h0FFF, 16'h0, 1'b0, 1'b1, 3'b000);
    access("R3", 16'h1FFF, 16'h0, 1'b0, 1'b1, 3'b000);
    access("R10", 16'h2000, 16'h0, 1'b0, 1'b1, 3'b010);
  endtask

  task automatic t_size();
    base_cfg();
    access("R5", 16'h2000, 16'h0, 1'b0, 1'b0, 3'b010);
    sizeEnB = 1'b1; sizeWordB = 1'b0;
    access("R5", 16'h2000, 16'h0, 1'b0, 1'b0, 3'b010);
    access("R5", 16'h2000, 16'h0, 1'b0, 1'b1, 3'b000);
    sizeWordB = 1'b1;
    access("R5", 16'h2000, 16'h0, 1'b0, 1'b1, 3'b010);
    access("R5", 16'h2000, 16'h0, 1'b0, 1'b0, 3'b000);
  endtask

  task automatic t_data();
    base_cfg(); cmpDataA = 16'h5A00; maskHiA = 8'hFF;
    access("R6", 16'h1000, 16'h5A77, 1'b0, 1'b0, 3'b101);
    access("R6", 16'h1000, 16'h5B00, 1'b0, 1'b0, 3'b100);
    cmpDataA = 16'h1234; maskLoA = 8'hFF;
    access("R6", 16'h1000, 16'h1234, 1'b0, 1'b1, 3'b101);
    access("R6", 16'h1000, 16'h1235, 1'b0, 1'b1, 3'b100);
    notEqA = 1'b1;
    access("R7", 16'h1000, 16'h1234, 1'b0, 1'b1, 3'b100);
    access("R7", 16'h1000, 16'h1235, 1'b0, 1'b1, 3'b101);
  endtask

  task automatic t_dir();
    base_cfg(); cmpDirEn = 3'b111; cmpDirWr = 3'b101;
    access("R8", 16'h1000, 16'h0, 1'b1, 1'b1, 3'b101);
    access("R8", 16'h1000, 16'h0, 1'b0, 1'b1, 3'b000);
    access("R8", 16'h2000, 16'h0, 1'b0, 1'b1, 3'b010);
    access("R8", 16'h2000, 16'h0, 1'b1, 1'b1, 3'b000);
  endtask

  task automatic t_burst();
    base_cfg();
    @(negedge clk);
    busValid = 1'b1; busAddr = 16'h1000; busWord = 1'b1;
    @(negedge clk);
    check("R9", 3'b101);
    busAddr = 16'h2000;
    @(negedge clk);
    check("R9", 3'b010);
    busValid = 1'b0;
    @(negedge clk);
    check("R9", 3'b000);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_exact();
    t_size();
    t_data();
    t_dir();
    t_burst();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule